// File: doc/BRIEF.md
# Retriggerable Deglitched Reset Pulse Generator

This block turns a slow power-detect level (for example a bus-power indication that has already been synchronised to the local clock) into an active-low pulse on a shared reset/fault line. A rising level counts as an event only once it has stayed high for a deglitch window. Each event, and each fault request from the neighbouring safety controller, pulls the line low for a fixed pulse length. All times are counted in periods of a slow tick that an outside divider supplies, so the same block serves any system clock.

A qualified event that arrives while a pulse is still running does not get lost. It restarts the full pulse length, so the line is released one full pulse length after the most recent event. A level that rises and then stays high gives exactly one event. The input must fall and rise again before it can give another. When a fault request and a detect event overlap, the line stays low until whichever pulse ends later has run out. The parameter `SHARED_TIMER` chooses the implementation: one reloadable timer for both sources, or one timer per source with the two busy flags combined.

Top module: `dgp_top`

## Requirements
- R1: After reset, `pull_n` is 1 and the deglitch and pulse counters are cleared. A level that was partly counted before reset needs a full `DGL_TICKS` ticks after reset to qualify.
- R2: The detect input qualifies once `det_lvl` has been 1 on `DGL_TICKS` consecutive tick cycles. If the level goes to 0 before that, the count is cleared and no pulse follows.
- R3: A qualified detect event drives `pull_n` to 0 from the cycle after qualification. The line returns to 1 on the `PULSE_TICKS`-th tick after the pulse was loaded.
- R4: While `det_lvl` stays 1, only one event is produced. The level must return to 0 and then rise again before another event can occur.
- R5: A qualified event that arrives while `pull_n` is 0 reloads the full pulse length. The line is then released `PULSE_TICKS` ticks after the new event.
- R6: Each clock cycle in which `flt_req` is 1 starts, or restarts, a pulse of `PULSE_TICKS` ticks on the same output.
- R7: When a fault pulse and a detect pulse overlap, `pull_n` stays 0 until the pulse that ends later has expired.
- R8: `pull_n` encodes 0 as pull-down enabled and 1 as released. It falls only in the cycle after a detect event or a fault request.
- R9: Time passes only on cycles with `ms_tick` = 1. Without ticks, a high detect level never qualifies and an active pulse never ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| det_lvl | input | 1 | Synchronised power-detect level |
| ms_tick | input | 1 | One-cycle time-base tick; all windows are counted in these |
| flt_req | input | 1 | Fault pulse request from the safety controller |
| pull_n | output | 1 | Active-low pull-down enable for the shared reset/fault line |

## Verification
Two things can land on the same clock cycle: a load request and a tick. This happens when a fault request or a detect qualification arrives on a tick cycle while a pulse is already counting down. The bench starts a fault request in the same cycle as a tick, and it also lets a detect pulse and a fault pulse overlap in both orders. It then checks whether the line is released at the later of the two computed end times, or one tick early, which is what happens if the decrement wins over the reload.

// File: rtl/dgp_pkg.sv
package dgp_pkg;

   // counter width able to hold values 0..max_val
   function automatic int unsigned cnt_width(input int unsigned max_val);
      int unsigned w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction

   typedef enum logic [0:0] {
      QS_ARMED = 1'b0,   // counting high ticks, event not yet issued
      QS_SPENT = 1'b1    // event issued, waiting for the level to drop
   } qual_state_e;

endpackage

// File: rtl/dgp_qualify.sv
module dgp_qualify
   import dgp_pkg::*;
#(
   parameter int unsigned DGL_TICKS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic tick,
   output logic stb
);
   localparam int unsigned CW = cnt_width(DGL_TICKS);
   localparam logic [CW-1:0] LAST = CW'(DGL_TICKS - 1);

   qual_state_e   st_q;
   logic [CW-1:0] cnt_q;
   logic          stb_q;

   initial begin
      assert (DGL_TICKS >= 1) else $error("DGL_TICKS must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= QS_ARMED;
         cnt_q <= '0;
         stb_q <= 1'b0;
      end else begin
         stb_q <= 1'b0;
         if (!lvl) begin
            st_q  <= QS_ARMED;
            cnt_q <= '0;
         end else if (st_q == QS_ARMED && tick) begin
            if (cnt_q == LAST) begin
               st_q  <= QS_SPENT;
               cnt_q <= '0;
               stb_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign stb = stb_q;
endmodule

// File: rtl/dgp_stretch.sv
module dgp_stretch
   import dgp_pkg::*;
#(
   parameter int unsigned PULSE_TICKS = 57
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic tick,
   output logic busy
);
   localparam int unsigned CW = cnt_width(PULSE_TICKS);
   localparam logic [CW-1:0] FULL = CW'(PULSE_TICKS);

   logic [CW-1:0] rem_q;

   initial begin
      assert (PULSE_TICKS >= 1) else $error("PULSE_TICKS must be at least 1");
   end

   // reload outranks the decrement so a restart on a tick cycle keeps full length
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rem_q <= '0;
      else if (load)
         rem_q <= FULL;
      else if (tick && rem_q != '0)
         rem_q <= rem_q - 1'b1;
   end

   assign busy = (rem_q != '0);
endmodule

// File: rtl/dgp_top.sv
module dgp_top
   import dgp_pkg::*;
#(
   parameter int unsigned DGL_TICKS    = 10,
   parameter int unsigned PULSE_TICKS  = 57,
   parameter bit          SHARED_TIMER = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic det_lvl,
   input  logic ms_tick,
   input  logic flt_req,
   output logic pull_n
);
   logic qual_stb;
   logic busy;

   dgp_qualify #(.DGL_TICKS(DGL_TICKS)) u_qual (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (det_lvl),
      .tick (ms_tick),
      .stb  (qual_stb)
   );

   generate
      if (SHARED_TIMER) begin : g_shared
         // every load restarts a full window, which is never earlier than the old end
         dgp_stretch #(.PULSE_TICKS(PULSE_TICKS)) u_tmr (
            .clk  (clk),
            .rst_n(rst_n),
            .load (qual_stb | flt_req),
            .tick (ms_tick),
            .busy (busy)
         );
      end else begin : g_split
         logic busy_det;
         logic busy_flt;
         dgp_stretch #(.PULSE_TICKS(PULSE_TICKS)) u_tmr_det (
            .clk  (clk),
            .rst_n(rst_n),
            .load (qual_stb),
            .tick (ms_tick),
            .busy (busy_det)
         );
         dgp_stretch #(.PULSE_TICKS(PULSE_TICKS)) u_tmr_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .load (flt_req),
            .tick (ms_tick),
            .busy (busy_flt)
         );
         assign busy = busy_det | busy_flt;
      end
   endgenerate

   assign pull_n = ~busy;
endmodule

// File: rtl/dgp_checks.sv
module dgp_checks (
   input logic clk,
   input logic rst_n,
   input logic det_lvl,
   input logic ms_tick,
   input logic flt_req,
   input logic qual_stb,
   input logic pull_n
);
   // R1: line released on the first cycle out of reset
   a_r1_released_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> pull_n);

   // R2: qualification only follows a tick seen with the level high
   a_r2_qual_on_high_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(qual_stb) |-> $past(ms_tick && det_lvl));

   // R4: one event per held level
   a_r4_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      qual_stb |=> !qual_stb);

   // R3: release happens only on a tick
   a_r3_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull_n) |-> $past(ms_tick));

   // R6: a fault request pulls the line next cycle
   a_r6_fault_pulls: assert property (@(posedge clk) disable iff (!rst_n)
      flt_req |=> !pull_n);

   // R8: the line falls only after an event
   a_r8_fall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pull_n) |-> $past(flt_req || qual_stb));

   // R9: with no tick and no event the line holds
   a_r9_frozen_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!ms_tick && !flt_req && !qual_stb) |=> $stable(pull_n));
endmodule

bind dgp_top dgp_checks u_chk (.*);

// File: tb/sim_dgp_top.sv
module sim_dgp_top;
   localparam int unsigned DGL  = 4;
   localparam int unsigned PLS  = 10;
   localparam int          NSEG = 24;

   typedef struct packed {
      logic [3:0] req;
      logic       det;
      logic       flt;   // applied in the first slot only
      logic       exp_n;
      logic [4:0] len;   // slots, each one tick long
   } seg_t;

   // slot-level expectations derived from DGL=4 and PLS=10
   localparam seg_t SEGS [NSEG] = '{
      '{4'd1, 1'b0, 1'b0, 1'b1, 5'd1 },  // R1 idle
      '{4'd2, 1'b1, 1'b0, 1'b1, 5'd3 },  // R2 short high
      '{4'd2, 1'b0, 1'b0, 1'b1, 5'd1 },  // R2 drop clears count
      '{4'd2, 1'b1, 1'b0, 1'b1, 5'd3 },  // R2 counting
      '{4'd3, 1'b1, 1'b0, 1'b0, 5'd10},  // R3 pulse body
      '{4'd4, 1'b1, 1'b0, 1'b1, 5'd3 },  // R4 held high, no retrigger
      '{4'd4, 1'b0, 1'b0, 1'b1, 5'd1 },  // R4 fall
      '{4'd2, 1'b1, 1'b0, 1'b1, 5'd3 },  // R2 exactly four ticks
      '{4'd2, 1'b1, 1'b0, 1'b0, 5'd1 },
      '{4'd5, 1'b0, 1'b0, 1'b0, 5'd1 },  // R5 low during pulse
      '{4'd5, 1'b1, 1'b0, 1'b0, 5'd13},  // R5 extended
      '{4'd5, 1'b1, 1'b0, 1'b1, 5'd2 },
      '{4'd5, 1'b0, 1'b0, 1'b1, 5'd1 },
      '{4'd6, 1'b0, 1'b1, 1'b0, 5'd10},  // R6 fault on tick cycle
      '{4'd6, 1'b0, 1'b0, 1'b1, 5'd1 },
      '{4'd7, 1'b1, 1'b0, 1'b1, 5'd3 },  // R7 detect first
      '{4'd7, 1'b1, 1'b0, 1'b0, 5'd3 },
      '{4'd7, 1'b1, 1'b1, 1'b0, 5'd10},  // R7 fault later, ends later
      '{4'd7, 1'b1, 1'b0, 1'b1, 5'd1 },
      '{4'd7, 1'b0, 1'b0, 1'b1, 5'd1 },
      '{4'd7, 1'b0, 1'b1, 1'b0, 5'd1 },  // R7 fault first
      '{4'd7, 1'b1, 1'b0, 1'b0, 5'd13},  // R7 detect ends later
      '{4'd7, 1'b1, 1'b0, 1'b1, 5'd1 },
      '{4'd8, 1'b0, 1'b0, 1'b1, 5'd1 }   // R8 released
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic det_lvl = 1'b0;
   logic ms_tick = 1'b0;
   logic flt_req = 1'b0;
   logic pull_n;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dgp_top #(.DGL_TICKS(DGL), .PULSE_TICKS(PLS), .SHARED_TIMER(1'b1)) u0 (
      .clk    (clk),
      .rst_n  (rst_n),
      .det_lvl(det_lvl),
      .ms_tick(ms_tick),
      .flt_req(flt_req),
      .pull_n (pull_n)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic check(input string tag, input logic exp_n);
      n_chk++;
      if (pull_n !== exp_n) begin
         n_bad++;
         $display("FAIL %s: pull_n actual=%b expected=%b at cycle %0d", tag, pull_n, exp_n, cyc);
      end
   endtask

   // called at a falling edge; leaves at a falling edge after four clocks
   task automatic slot(input logic d, input logic f, input logic with_tick);
      det_lvl = d;
      flt_req = f;
      ms_tick = with_tick;
      @(negedge clk);
      flt_req = 1'b0;
      ms_tick = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset state", 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 1'b1);

      // table walk
      for (int s = 0; s < NSEG; s++) begin
         for (int k = 0; k < int'(SEGS[s].len); k++) begin
            slot(SEGS[s].det, SEGS[s].flt && (k == 0), 1'b1);
            n_chk++;
            if (pull_n !== SEGS[s].exp_n) begin
               n_bad++;
               $display("FAIL R%0d seg %0d slot %0d: pull_n actual=%b expected=%b",
                        SEGS[s].req, s, k, pull_n, SEGS[s].exp_n);
            end
         end
      end

      // R9: level high with no ticks never qualifies
      slot(1'b1, 1'b0, 1'b0);
      repeat (8) slot(1'b1, 1'b0, 1'b0);
      check("R9 no tick no qualify", 1'b1);
      slot(1'b0, 1'b0, 1'b0);
      // R9: a pulse without ticks never ends
      slot(1'b0, 1'b1, 1'b0);
      repeat (8) slot(1'b0, 1'b0, 1'b0);
      check("R9 pulse frozen", 1'b0);
      for (int k = 0; k < int'(PLS) - 1; k++) slot(1'b0, 1'b0, 1'b1);
      check("R9 one tick short", 1'b0);
      slot(1'b0, 1'b0, 1'b1);
      check("R9 released on last tick", 1'b1);

      // R1: reset during a pulse releases the line
      slot(1'b0, 1'b1, 1'b1);
      check("R6 pulse before reset", 1'b0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 reset mid pulse", 1'b1);
      rst_n = 1'b1;
      slot(1'b0, 1'b0, 1'b1);
      check("R1 stays released", 1'b1);

      // R1: partial deglitch count is cleared by reset
      repeat (3) slot(1'b1, 1'b0, 1'b1);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) slot(1'b1, 1'b0, 1'b1);
      check("R1 count cleared", 1'b1);
      slot(1'b1, 1'b0, 1'b1);
      check("R2 full window after reset", 1'b0);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule